// File: doc/BRIEF.md
# Protected Byte-Array Programming Controller

This block fronts a small byte-wide non-volatile data array, modelled here as an internal memory whose cells are erased to all ones and programmed by clearing bits. A host reaches it through three registers, selected by `regSel`: control (select 0), address (select 1) and data (select 2). A read copies the addressed byte into the data register and holds the processor for a few cycles. Erase and program operations are guarded by an arm-then-fire sequence. The host first sets the arm bit. Within four cycles it must set the go bit. Any other timing is refused.

Once an operation is accepted, the go bit reads back as one until the timed operation ends. While it is set, the controller refuses every new read, erase or program request. The programming time is a parameter, `PROG_CYCLES`, that stands in for the real cell timing. An operation can erase and program in one pass, erase only, or program only. A program-only pass stores the AND of the old and new byte, so the target must be erased first. An optional ready interrupt is high whenever the controller is idle.

The block has two resets. `porN` is a power-on reset that clears everything, including the array. `rstN` is a system reset that clears the registers but lets an operation already in flight run to completion.

Top module: `nvm_controller`

## Requirements
- R1: After `porN` and `rstN`, the control register reads 0x00, `stall` and `irq` are low, and every array byte reads back 0xFF.
- R2: The control register has these fields: bit 0 read-start (always reads 0), bit 1 go, bit 2 arm, bit 3 interrupt enable, bits 5:4 mode. The arm bit reads 1 for exactly 4 cycles after it is written. A go write is accepted only when the arm write came 1 to 4 cycles earlier. A go write 5 or more cycles after arm is refused.
- R3: After an accepted go, the go bit reads 1 for `PROG_CYCLES` cycles in split modes and for 2×`PROG_CYCLES` cycles in the combined mode. While the go bit is set, read, erase and program requests are refused.
- R4: An accepted go raises `stall` for exactly 2 cycles, starting in the cycle after the write.
- R5: Writing read-start while idle raises `stall` for exactly 4 cycles. The data register holds the addressed byte from the cycle after the write.
- R6: Mode 00 (combined) leaves the target byte equal to the data register value that was captured at go.
- R7: Mode 01 (erase only) leaves the target byte at 0xFF.
- R8: Mode 10 (program only) leaves the target byte equal to the old byte AND the captured data.
- R9: A go write with mode 11 is refused: the go bit stays 0 and the array is unchanged.
- R10: `irq` is 1 exactly when interrupt enable is set and the go bit is 0.
- R11: Pulsing `rstN` during an operation clears the address register, the data register and the control fields. The go bit stays set until the operation finishes, and the operation still writes the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low; clears everything including the array |
| rstN | input | 1 | Asynchronous system reset, active low; spares an in-flight operation |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 address, 2 data |
| regWdata | input | 8 | Register write data |
| ctrlOut | output | 8 | Control register readback |
| addrOut | output | ADDR_W | Address register |
| dataOut | output | 8 | Data register |
| stall | output | 1 | Processor hold request |
| irq | output | 1 | Ready interrupt |

## Verification
A register write takes effect at the clock edge that samples it. The go bit, the arm bit, `stall` and the data register are all registered, so each of them changes in the cycle right after that edge. The bench samples at the falling edge that follows the write task and counts from there: 4 cycles of arm, 2 or 4 cycles of `stall`, and `PROG_CYCLES` or twice that of busy. A programmed byte is judged only by a read issued after the go bit has cleared. The bench compares it against a model array that is updated with the mode rules.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    MODE_ATOMIC = 2'b00,
    MODE_ERASE  = 2'b01,
    MODE_WRITE  = 2'b10,
    MODE_RSVD   = 2'b11
  } progMode_t;

  localparam int BIT_RE      = 0;
  localparam int BIT_PE      = 1;
  localparam int BIT_MPE     = 2;
  localparam int BIT_IE      = 3;
  localparam int BIT_MODE_LO = 4;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int ARM_WINDOW = 4;
  localparam int PROG_STALL = 2;
  localparam int READ_STALL = 4;

  typedef struct packed {
    logic latchOp;
    logic commit;
    logic doRead;
  } nvmStrobe_t;
endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int PROG_CYCLES = 8
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [1:0] regSel,
  input  logic [5:0] regWdata,
  output logic [7:0] ctrlOut,
  output logic       stall,
  output logic       irq,
  output nvmStrobe_t strb,
  output progMode_t  opMode
);
  localparam int OPCNT_W = $clog2(2 * PROG_CYCLES + 1);
  localparam int WIN_W   = $clog2(ARM_WINDOW + 1);
  localparam int STALL_W = $clog2(READ_STALL + 1);

  logic [WIN_W-1:0]   winCnt;
  logic [STALL_W-1:0] stallCnt;
  logic [OPCNT_W-1:0] opCnt;
  logic               busy;
  logic               irqEn;
  progMode_t          modeReg;

  logic      ctlWr, winOpen, startReq, readReq, finish;
  progMode_t reqMode;

  assign ctlWr    = regWr && (regSel == SEL_CTRL);
  assign winOpen  = (winCnt != '0);
  assign reqMode  = progMode_t'(regWdata[BIT_MODE_LO +: 2]);
  assign startReq = ctlWr && regWdata[BIT_PE] && winOpen && !busy && (reqMode != MODE_RSVD);
  assign readReq  = ctlWr && regWdata[BIT_RE] && !busy && !startReq;
  assign finish   = busy && (opCnt == OPCNT_W'(1));

  // Registers visible to software: cleared by either reset.
  always_ff @(posedge clk or negedge porN or negedge rstN) begin
    if (!porN || !rstN) begin
      winCnt   <= '0;
      stallCnt <= '0;
      irqEn    <= 1'b0;
      modeReg  <= MODE_ATOMIC;
    end else begin
      if (ctlWr) irqEn <= regWdata[BIT_IE];
      if (ctlWr && !busy) modeReg <= reqMode;

      if (ctlWr && regWdata[BIT_MPE] && !busy) winCnt <= WIN_W'(ARM_WINDOW);
      else if (startReq)                       winCnt <= '0;
      else if (winOpen)                        winCnt <= winCnt - 1'b1;

      if (startReq)            stallCnt <= STALL_W'(PROG_STALL);
      else if (readReq)        stallCnt <= STALL_W'(READ_STALL);
      else if (stallCnt != '0) stallCnt <= stallCnt - 1'b1;
    end
  end

  // Operation engine: only power-on reset stops it.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      busy   <= 1'b0;
      opCnt  <= '0;
      opMode <= MODE_ATOMIC;
    end else if (startReq) begin
      busy   <= 1'b1;
      opMode <= reqMode;
      opCnt  <= (reqMode == MODE_ATOMIC) ? OPCNT_W'(2 * PROG_CYCLES) : OPCNT_W'(PROG_CYCLES);
    end else if (finish) begin
      busy  <= 1'b0;
      opCnt <= '0;
    end else if (busy) begin
      opCnt <= opCnt - 1'b1;
    end
  end

  always_comb begin
    strb.latchOp = startReq;
    strb.commit  = finish;
    strb.doRead  = readReq;
  end

  assign stall   = (stallCnt != '0);
  assign irq     = irqEn && !busy;
  assign ctrlOut = {2'b00, modeReg, irqEn, winOpen, busy, 1'b0};
endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regWdata,
  input  nvmStrobe_t        strb,
  input  progMode_t         opMode,
  output logic [ADDR_W-1:0] addrOut,
  output logic [7:0]        dataOut
);
  logic [7:0]        cells [DEPTH];
  logic [ADDR_W-1:0] latAddr;
  logic [7:0]        latData;
  logic [7:0]        newByte;

  always_ff @(posedge clk or negedge porN or negedge rstN) begin
    if (!porN || !rstN) begin
      addrOut <= '0;
      dataOut <= '0;
    end else begin
      if (regWr && regSel == SEL_ADDR) addrOut <= regWdata[ADDR_W-1:0];
      if (strb.doRead)                 dataOut <= cells[addrOut];
      else if (regWr && regSel == SEL_DATA) dataOut <= regWdata;
    end
  end

  // Captured operands survive a system reset so the operation completes.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      latAddr <= '0;
      latData <= '0;
    end else if (strb.latchOp) begin
      latAddr <= addrOut;
      latData <= dataOut;
    end
  end

  always_comb begin
    unique case (opMode)
      MODE_ERASE: newByte = 8'hFF;
      MODE_WRITE: newByte = cells[latAddr] & latData;
      default:    newByte = latData;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (strb.commit) begin
      cells[latAddr] <= newByte;
    end
  end
endmodule

// File: rtl/nvm_controller.sv
module nvm_controller
  import nvm_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int PROG_CYCLES = 8,
  parameter int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regWdata,
  output logic [7:0]        ctrlOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [7:0]        dataOut,
  output logic              stall,
  output logic              irq
);
  nvmStrobe_t strb;
  progMode_t  opMode;

  nvm_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata[5:0]), .ctrlOut(ctrlOut), .stall(stall), .irq(irq),
    .strb(strb), .opMode(opMode)
  );

  nvm_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .porN(porN), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .strb(strb), .opMode(opMode),
    .addrOut(addrOut), .dataOut(dataOut)
  );
endmodule

// File: rtl/nvm_checker.sv
module nvm_checker
  import nvm_pkg::*;
(
  input logic clk,
  input logic porN,
  input logic rstN,
  input logic busyBit,
  input logic armBit,
  input logic stall,
  input logic irq
);
  logic [3:0] stallRun;

  always_ff @(posedge clk or negedge porN or negedge rstN) begin
    if (!porN || !rstN) stallRun <= '0;
    else if (stall)     stallRun <= (stallRun == 4'hF) ? stallRun : stallRun + 1'b1;
    else                stallRun <= '0;
  end

  // R2: an operation can only begin while the arm window is open
  assert_start_armed_R2: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(busyBit) |-> $past(armBit));

  // R4: an operation start holds the processor
  assert_start_stalls_R4: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(busyBit) |-> stall);

  // R5: no hold lasts longer than the read hold
  assert_stall_bounded_R5: assert property (@(posedge clk) disable iff (!porN || !rstN)
    stallRun <= 4'(READ_STALL));

  // R10: no ready interrupt while an operation runs
  assert_no_irq_busy_R10: assert property (@(posedge clk) disable iff (!porN || !rstN)
    busyBit |-> !irq);
endmodule

bind nvm_controller nvm_checker u_chk (
  .clk(clk), .porN(porN), .rstN(rstN),
  .busyBit(ctrlOut[1]), .armBit(ctrlOut[2]), .stall(stall), .irq(irq)
);

// File: tb/tb_nvm_controller.sv
module tb_nvm_controller;
  localparam int T     = 8;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       porN = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] ctrlOut, dataOut;
  logic [6:0] addrOut;
  logic       stall, irq;

  int   checks = 0, errs = 0;
  bit   ieBit = 1'b0;
  bit   ended = 1'b0;
  logic [7:0] model [DEPTH];

  nvm_controller #(.DEPTH(DEPTH), .PROG_CYCLES(T)) dut (
    .clk(clk), .porN(porN), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .ctrlOut(ctrlOut), .addrOut(addrOut),
    .dataOut(dataOut), .stall(stall), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  endtask

  function automatic logic [7:0] ctl(logic [1:0] mode, bit pe, bit mpe, bit re);
    return {2'b00, mode, ieBit, mpe, pe, re};
  endfunction

  function automatic int expDur(logic [1:0] mode, bit ok);
    if (!ok || mode == 2'b11) return 0;
    return (mode == 2'b00) ? 2 * T : T;
  endfunction

  function automatic logic [7:0] expByte(logic [1:0] mode, logic [7:0] old, logic [7:0] d);
    case (mode)
      2'b00:   return d;
      2'b01:   return 8'hFF;
      2'b10:   return old & d;
      default: return old;
    endcase
  endfunction

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = s; regWdata = d;
    @(posedge clk);
    #1 regWr = 1'b0;
  endtask

  task automatic doProg(logic [1:0] mode, logic [6:0] a, logic [7:0] d, int gap, string req);
    bit ok;
    int busyN;
    int dur;
    ok = (gap >= 1) && (gap <= 4) && (mode != 2'b11);
    dur = expDur(mode, ok);
    busyN = 0;
    wr(2'd1, {1'b0, a});
    wr(2'd2, d);
    wr(2'd0, ctl(mode, 0, 1, 0));
    if (gap > 1) repeat (gap - 1) @(posedge clk);
    wr(2'd0, ctl(mode, 1, 0, 0));
    for (int i = 0; i < 2 * T + 4; i++) begin
      @(negedge clk);
      if (ctrlOut[1]) busyN++;
      if (i < 3) chk(stall == (dur != 0 && i < 2), "R4 stall", stall, (dur != 0 && i < 2));
      if (i == 0 && ieBit) chk(irq == (dur == 0), "R10 irq during op", irq, (dur == 0));
    end
    chk(busyN == dur, req, busyN, dur);
    if (dur != 0) model[a] = expByte(mode, model[a], d);
  endtask

  task automatic rd(logic [6:0] a, output logic [7:0] v);
    wr(2'd1, {1'b0, a});
    wr(2'd0, ctl(2'b00, 0, 0, 1));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i == 0) v = dataOut;
      chk(stall == (i < 4), "R5 read stall", stall, (i < 4));
    end
  endtask

  task automatic rdCheck(logic [6:0] a, string req);
    logic [7:0] v;
    rd(a, v);
    chk(v == model[a], req, v, model[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

    repeat (3) @(posedge clk);
    #1 porN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    chk(ctrlOut == 8'h00, "R1 ctrl reset", ctrlOut, 8'h00);
    chk(stall == 1'b0 && irq == 1'b0, "R1 stall/irq reset", {stall, irq}, 0);
    rdCheck(7'd0, "R1 erased array");
    rdCheck(7'd127, "R1 erased array");

    // R2: arm bit lifetime, then late go refused
    wr(2'd0, ctl(2'b00, 0, 1, 0));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ctrlOut[2] == (i < 4), "R2 arm window", ctrlOut[2], (i < 4));
    end
    wr(2'd0, ctl(2'b00, 1, 0, 0));
    @(negedge clk);
    chk(ctrlOut[1] == 1'b0, "R2 late go refused", ctrlOut[1], 0);

    // Directed mode and window corners
    doProg(2'b00, 7'd5, 8'h3C, 1, "R6 R3 combined duration");
    rdCheck(7'd5, "R6 combined stores data");
    doProg(2'b01, 7'd5, 8'h00, 4, "R7 R3 erase duration");
    rdCheck(7'd5, "R7 erase to FF");
    doProg(2'b10, 7'd5, 8'hA5, 2, "R8 R3 write-only duration");
    doProg(2'b10, 7'd5, 8'h0F, 3, "R8 write-only duration");
    rdCheck(7'd5, "R8 AND result");
    doProg(2'b11, 7'd5, 8'h00, 1, "R9 reserved mode refused");
    rdCheck(7'd5, "R9 array unchanged");
    doProg(2'b01, 7'd9, 8'h00, 1, "R7 erase");
    doProg(2'b00, 7'd9, 8'h12, 5, "R2 go after 5 cycles refused");
    rdCheck(7'd9, "R2 array unchanged");

    // R3: requests during busy refused
    wr(2'd1, 8'd10);
    wr(2'd2, 8'h77);
    wr(2'd0, ctl(2'b00, 0, 1, 0));
    wr(2'd0, ctl(2'b00, 1, 0, 0));
    model[10] = 8'h77;
    wr(2'd2, 8'h11);
    wr(2'd0, ctl(2'b00, 0, 0, 1));
    @(negedge clk);
    chk(dataOut == 8'h11, "R3 read refused while busy", dataOut, 8'h11);
    chk(ctrlOut[1] == 1'b1, "R3 still busy", ctrlOut[1], 1);
    wr(2'd0, ctl(2'b01, 0, 1, 0));
    wr(2'd0, ctl(2'b01, 1, 0, 0));
    repeat (2 * T + 2) @(posedge clk);
    @(negedge clk);
    chk(ctrlOut[1] == 1'b0, "R3 op finished", ctrlOut[1], 0);
    rdCheck(7'd10, "R3 erase refused while busy");

    // R10: interrupt follows idle
    ieBit = 1'b1;
    wr(2'd0, ctl(2'b00, 0, 0, 0));
    @(negedge clk);
    chk(irq == 1'b1, "R10 irq when idle", irq, 1);
    doProg(2'b01, 7'd33, 8'h00, 2, "R10 R7 erase with irq");
    chk(irq == 1'b1, "R10 irq after done", irq, 1);
    ieBit = 1'b0;
    wr(2'd0, ctl(2'b00, 0, 0, 0));
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq disabled", irq, 0);

    // R11: system reset during an operation
    wr(2'd1, 8'd20);
    wr(2'd2, 8'h5A);
    wr(2'd0, ctl(2'b00, 0, 1, 0));
    wr(2'd0, ctl(2'b00, 1, 0, 0));
    model[20] = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    chk(ctrlOut == 8'h02, "R11 only go bit survives", ctrlOut, 8'h02);
    chk(addrOut == 7'd0 && dataOut == 8'h00, "R11 regs cleared", {addrOut, dataOut}, 0);
    repeat (2 * T + 2) @(posedge clk);
    @(negedge clk);
    chk(ctrlOut[1] == 1'b0, "R11 op finished", ctrlOut[1], 0);
    rdCheck(7'd20, "R11 op completed across reset");

    // Random operations with readback
    for (int n = 0; n < 40; n++) begin
      logic [1:0] m;
      logic [6:0] a;
      logic [7:0] d;
      int g;
      m = 2'($urandom % 3);
      a = 7'($urandom % 16);
      d = 8'($urandom);
      g = 1 + int'($urandom % 5);
      doProg(m, a, d, g, "R3 R6 R7 R8 random duration");
      rd(a, v);
      chk(v == model[a], "R6 R7 R8 random readback", v, model[a]);
    end

    summary();
  end
endmodule